// File: doc/BRIEF.md
# Disk Power Mode Controller

This block keeps track of the power state of a storage device and moves it between a fully active state, three progressively deeper idle levels, standby (spindle stopped) and sleep. It is driven by decoded host command strobes, a millisecond tick, an asynchronous hard reset and a synchronous soft reset, and it reports the current mode, whether the spindle is up to speed, and whether a media command is being held while the spindle spins up.

Two independent mechanisms push the device towards standby at the same time: a host-programmed inactivity timer, and an advanced power management ladder that steps down one idle level after a dwell time that depends on the programmed level. Whichever reaches standby first wins. Leaving standby needs a programmable spin-up time; leaving sleep is possible only through a reset.

Top module: `disk_pwr_mgr`

## Requirements
- R1: While `hardRstN` is low and after it rises, `mode` is 0, `spinReady` is 1 and `cmdHold` is 0; the inactivity timer is disabled and the power management ladder is off.
- R2: `mode` uses 0 = active, 1, 2, 3 = idle levels from shallow to deep, 4 = standby, 5 = sleep; `spinReady` is 1 exactly in modes 0 to 3.
- R3: Command classes are 0 media, 1 idle, 2 standby, 3 sleep, 4 set timer (`cmdArg` = tick count), 5 set level (`cmdArg` = level), 6 level off, 7 reserved. From any awake mode, class 2 gives mode 4, class 3 gives mode 5 and class 1 gives mode 1 on the next clock.
- R4: With a timer value T from 1 to 255, after T ticks without a command in modes 0 to 3 the mode becomes 4 on the clock of the T-th tick; every accepted command restarts the count; T = 0 disables the timer.
- R5: Class 5 with `cmdArg` from 01h to FEh enables the ladder; 00h and FFh leave the setting unchanged. In modes 0 to 3, after D ticks without a command the mode steps down by one (3 steps to 4), D = DWELL_BASE shifted left by `cmdArg[7:6]` (2, 4, 8, 16 by default); the dwell restarts after each step and each command. Class 6 turns the ladder off.
- R6: With both the timer and the ladder set, standby is entered at whichever of the two expires first.
- R7: A media command in idle levels 1 to 3 gives mode 0 on the next clock.
- R8: A media command in standby raises `cmdHold` and keeps mode 4 with `spinReady` low for SPINUP_MS ticks; on the SPINUP_MS-th tick mode becomes 0, `spinReady` 1 and `cmdHold` 0. An idle command in standby spins up the same way to mode 1 without raising `cmdHold`.
- R9: In sleep every command class is ignored: mode stays 5 and no setting changes. A hard reset leaves sleep to mode 0 at once.
- R10: A soft reset keeps the timer and ladder settings; from modes 0 to 3 it gives mode 0 on the next clock; from mode 4 or 5 it gives mode 4 followed by the spin-up of R8 to mode 0.
- R11: Reserved class 7 changes no mode and no setting and does not restart the inactivity or dwell counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hardRstN | input | 1 | Asynchronous hard reset, active low; clears all settings |
| softRst | input | 1 | Synchronous soft reset, one-cycle pulse |
| msTick | input | 1 | One-cycle pulse per millisecond |
| cmdValid | input | 1 | Command strobe |
| cmdClass | input | 3 | Decoded command class |
| cmdArg | input | 8 | Command argument (timer count or level) |
| mode | output | 3 | Current power mode |
| spinReady | output | 1 | Spindle up to speed |
| cmdHold | output | 1 | Media command waiting for spin-up |

## Verification
The hardest situation to reach is the race between the two standby triggers, because the ladder has to be partway down its idle levels at the exact tick the inactivity timer expires. The stimulus programs a timer value and a short dwell so that the timer expires on a tick where the ladder is one tick into its second idle level, then swaps the ratio so the ladder reaches standby before the timer. Settings kept across a soft reset are exposed by leaving sleep through a soft reset and timing the next automatic standby.

// File: rtl/disk_pwr_pkg.sv
package disk_pwr_pkg;

  typedef enum logic [2:0] {
    MODE_ACTIVE  = 3'd0,
    MODE_IDLE1   = 3'd1,
    MODE_IDLE2   = 3'd2,
    MODE_IDLE3   = 3'd3,
    MODE_STANDBY = 3'd4,
    MODE_SLEEP   = 3'd5
  } pwrMode_e;

  typedef enum logic [2:0] {
    CMD_MEDIA     = 3'd0,
    CMD_IDLE      = 3'd1,
    CMD_STANDBY   = 3'd2,
    CMD_SLEEP     = 3'd3,
    CMD_SET_TIMER = 3'd4,
    CMD_SET_LEVEL = 3'd5,
    CMD_LEVEL_OFF = 3'd6,
    CMD_RSVD      = 3'd7
  } cmdClass_e;

  // Strobes from the control FSM to the counter datapath
  typedef struct packed {
    logic reloadAll;    // restart inactivity and dwell counts
    logic reloadDwell;  // restart dwell count after a ladder step
    logic countEn;      // awake: counts advance on ticks
    logic spinEn;       // spin-up in progress
    logic spinRestart;  // restart spin-up count
    logic setTimer;
    logic setLevel;
    logic clrLevel;
  } dpCtl_t;

endpackage

// File: rtl/disk_pwr_dp.sv
module disk_pwr_dp
  import disk_pwr_pkg::*;
#(
  parameter int TIMER_W    = 8,
  parameter int DWELL_BASE = 2,
  parameter int SPINUP_MS  = 3
) (
  input  logic       clk,
  input  logic       hardRstN,
  input  logic       msTick,
  input  logic [7:0] cmdArg,
  input  dpCtl_t     ctl,
  output logic       timerFire,
  output logic       dwellFire,
  output logic       spinDone
);

  localparam int DWELL_MAX = DWELL_BASE << 3;
  localparam int DW        = $clog2(DWELL_MAX + 1);
  localparam int SW        = $clog2(SPINUP_MS + 1);

  logic [TIMER_W-1:0] timerVal;
  logic [TIMER_W-1:0] inactCnt;
  logic               levelOn;
  logic [1:0]         levelBand;
  logic [DW-1:0]      dwellCnt;
  logic [SW-1:0]      spinCnt;
  logic [DW-1:0]      bandLim [4];
  logic               levelArgOk;
  logic               tickRun;

  // Dwell per level band: lower band, shorter dwell
  for (genvar b = 0; b < 4; b++) begin : g_band
    assign bandLim[b] = DW'(DWELL_BASE << b);
  end

  assign levelArgOk = (cmdArg != 8'h00) && (cmdArg != 8'hFF);
  assign tickRun    = ctl.countEn && msTick;

  assign timerFire = tickRun && (timerVal != '0) &&
                     (TIMER_W'(inactCnt + 1'b1) == timerVal);
  assign dwellFire = tickRun && levelOn &&
                     (DW'(dwellCnt + 1'b1) == bandLim[levelBand]);
  assign spinDone  = ctl.spinEn && msTick && (spinCnt == SW'(SPINUP_MS - 1));

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) begin
      timerVal  <= '0;
      levelOn   <= 1'b0;
      levelBand <= 2'd0;
    end else begin
      if (ctl.setTimer) timerVal <= TIMER_W'(cmdArg);
      if (ctl.setLevel && levelArgOk) begin
        levelOn   <= 1'b1;
        levelBand <= cmdArg[7:6];
      end else if (ctl.clrLevel) begin
        levelOn <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) begin
      inactCnt <= '0;
      dwellCnt <= '0;
    end else if (ctl.reloadAll) begin
      inactCnt <= '0;
      dwellCnt <= '0;
    end else begin
      if (tickRun) inactCnt <= inactCnt + 1'b1;
      if (ctl.reloadDwell)  dwellCnt <= '0;
      else if (tickRun)     dwellCnt <= dwellCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN)                        spinCnt <= '0;
    else if (!ctl.spinEn || ctl.spinRestart) spinCnt <= '0;
    else if (msTick)                      spinCnt <= spinCnt + 1'b1;
  end

endmodule

// File: rtl/disk_pwr_ctrl.sv
module disk_pwr_ctrl
  import disk_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       hardRstN,
  input  logic       softRst,
  input  logic       cmdValid,
  input  logic [2:0] cmdClass,
  input  logic       timerFire,
  input  logic       dwellFire,
  input  logic       spinDone,
  output dpCtl_t     ctl,
  output pwrMode_e   modeQ,
  output logic       cmdHold
);

  logic      spinning;
  pwrMode_e  spinTarget;
  cmdClass_e cls;
  logic      awake;
  logic      cmdTake;
  logic [2:0] stepDown;

  assign cls      = cmdClass_e'(cmdClass);
  assign awake    = (modeQ < MODE_STANDBY);
  assign cmdTake  = cmdValid && (modeQ != MODE_SLEEP) && (cls != CMD_RSVD);
  assign stepDown = modeQ + 3'd1;

  always_comb begin
    ctl             = '0;
    ctl.countEn     = awake;
    ctl.spinEn      = spinning;
    ctl.spinRestart = softRst;
    ctl.reloadAll   = softRst || cmdTake || spinDone;
    ctl.reloadDwell = dwellFire;
    ctl.setTimer    = !softRst && cmdTake && (cls == CMD_SET_TIMER);
    ctl.setLevel    = !softRst && cmdTake && (cls == CMD_SET_LEVEL);
    ctl.clrLevel    = !softRst && cmdTake && (cls == CMD_LEVEL_OFF);
  end

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) begin
      modeQ      <= MODE_ACTIVE;
      spinning   <= 1'b0;
      spinTarget <= MODE_ACTIVE;
      cmdHold    <= 1'b0;
    end else if (softRst) begin
      cmdHold    <= 1'b0;
      spinTarget <= MODE_ACTIVE;
      if (awake) begin
        modeQ    <= MODE_ACTIVE;
        spinning <= 1'b0;
      end else begin
        modeQ    <= MODE_STANDBY;
        spinning <= 1'b1;
      end
    end else if (cmdTake) begin
      case (cls)
        CMD_MEDIA: begin
          if (modeQ == MODE_STANDBY) begin
            spinning   <= 1'b1;
            cmdHold    <= 1'b1;
            spinTarget <= MODE_ACTIVE;
          end else begin
            modeQ <= MODE_ACTIVE;
          end
        end
        CMD_IDLE: begin
          if (modeQ == MODE_STANDBY) begin
            if (!spinning) begin
              spinning   <= 1'b1;
              spinTarget <= MODE_IDLE1;
            end
          end else begin
            modeQ <= MODE_IDLE1;
          end
        end
        CMD_STANDBY: begin
          modeQ    <= MODE_STANDBY;
          spinning <= 1'b0;
          cmdHold  <= 1'b0;
        end
        CMD_SLEEP: begin
          modeQ    <= MODE_SLEEP;
          spinning <= 1'b0;
          cmdHold  <= 1'b0;
        end
        default: ;
      endcase
    end else if (spinDone) begin
      modeQ    <= spinTarget;
      spinning <= 1'b0;
      cmdHold  <= 1'b0;
    end else if (timerFire) begin
      modeQ <= MODE_STANDBY;
    end else if (dwellFire) begin
      modeQ <= pwrMode_e'(stepDown);
    end
  end

endmodule

// File: rtl/disk_pwr_mgr.sv
module disk_pwr_mgr
  import disk_pwr_pkg::*;
#(
  parameter int TIMER_W    = 8,
  parameter int DWELL_BASE = 2,
  parameter int SPINUP_MS  = 3
) (
  input  logic       clk,
  input  logic       hardRstN,
  input  logic       softRst,
  input  logic       msTick,
  input  logic       cmdValid,
  input  logic [2:0] cmdClass,
  input  logic [7:0] cmdArg,
  output logic [2:0] mode,
  output logic       spinReady,
  output logic       cmdHold
);

  dpCtl_t   ctl;
  pwrMode_e modeQ;
  logic     timerFire;
  logic     dwellFire;
  logic     spinDone;

  disk_pwr_ctrl u_ctrl (
    .clk       (clk),
    .hardRstN  (hardRstN),
    .softRst   (softRst),
    .cmdValid  (cmdValid),
    .cmdClass  (cmdClass),
    .timerFire (timerFire),
    .dwellFire (dwellFire),
    .spinDone  (spinDone),
    .ctl       (ctl),
    .modeQ     (modeQ),
    .cmdHold   (cmdHold)
  );

  disk_pwr_dp #(
    .TIMER_W    (TIMER_W),
    .DWELL_BASE (DWELL_BASE),
    .SPINUP_MS  (SPINUP_MS)
  ) u_dp (
    .clk       (clk),
    .hardRstN  (hardRstN),
    .msTick    (msTick),
    .cmdArg    (cmdArg),
    .ctl       (ctl),
    .timerFire (timerFire),
    .dwellFire (dwellFire),
    .spinDone  (spinDone)
  );

  assign mode      = modeQ;
  assign spinReady = (modeQ < MODE_STANDBY);

endmodule

// File: rtl/disk_pwr_chk.sv
module disk_pwr_chk (
  input logic       clk,
  input logic       hardRstN,
  input logic       softRst,
  input logic       msTick,
  input logic       cmdValid,
  input logic [2:0] cmdClass,
  input logic [2:0] mode,
  input logic       spinReady,
  input logic       cmdHold
);

  p_mode_range_r2: assert property (@(posedge clk) disable iff (!hardRstN)
    mode <= 3'd5);

  p_hold_standby_r8: assert property (@(posedge clk) disable iff (!hardRstN)
    cmdHold |-> (mode == 3'd4 && !spinReady));

  p_ready_on_tick_r8: assert property (@(posedge clk) disable iff (!hardRstN)
    $rose(spinReady) |-> $past(msTick));

  p_sleep_sticky_r9: assert property (@(posedge clk) disable iff (!hardRstN)
    (mode == 3'd5 && !softRst) |=> mode == 3'd5);

  p_ladder_step_r5: assert property (@(posedge clk) disable iff (!hardRstN)
    (mode <= 3'd3 && !cmdValid && !softRst) |=>
      (mode == $past(mode) || mode == $past(mode) + 3'd1 || mode == 3'd4));

  p_media_wake_r7: assert property (@(posedge clk) disable iff (!hardRstN)
    (cmdValid && cmdClass == 3'd0 && mode >= 3'd1 && mode <= 3'd3 && !softRst)
      |=> mode == 3'd0);

endmodule

bind disk_pwr_mgr disk_pwr_chk u_chk (
  .clk       (clk),
  .hardRstN  (hardRstN),
  .softRst   (softRst),
  .msTick    (msTick),
  .cmdValid  (cmdValid),
  .cmdClass  (cmdClass),
  .mode      (mode),
  .spinReady (spinReady),
  .cmdHold   (cmdHold)
);

// File: tb/disk_pwr_mgr_test.sv
module disk_pwr_mgr_test;

  logic       clk = 1'b0;
  logic       hardRstN = 1'b0;
  logic       softRst = 1'b0;
  logic       msTick = 1'b0;
  logic       cmdValid = 1'b0;
  logic [2:0] cmdClass = 3'd0;
  logic [7:0] cmdArg = 8'd0;
  logic [2:0] mode;
  logic       spinReady;
  logic       cmdHold;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  disk_pwr_mgr uut (
    .clk       (clk),
    .hardRstN  (hardRstN),
    .softRst   (softRst),
    .msTick    (msTick),
    .cmdValid  (cmdValid),
    .cmdClass  (cmdClass),
    .cmdArg    (cmdArg),
    .mode      (mode),
    .spinReady (spinReady),
    .cmdHold   (cmdHold)
  );

  task automatic expect_st(input logic [2:0] m, input logic rdy, input logic hld,
                           input string tag);
    checks++;
    if (mode !== m || spinReady !== rdy || cmdHold !== hld) begin
      errors++;
      $display("FAIL %s: mode=%0d ready=%0d hold=%0d expected mode=%0d ready=%0d hold=%0d",
               tag, mode, spinReady, cmdHold, m, rdy, hld);
    end
  endtask

  task automatic hard_reset();
    hardRstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    hardRstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic soft_reset();
    softRst = 1'b1;
    @(negedge clk);
    softRst = 1'b0;
    @(negedge clk);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      msTick = 1'b1;
      @(negedge clk);
      msTick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic cmd(input logic [2:0] c, input logic [7:0] a);
    cmdValid = 1'b1;
    cmdClass = c;
    cmdArg   = a;
    @(negedge clk);
    cmdValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    hardRstN = 1'b0;
    @(negedge clk);
    expect_st(3'd0, 1'b1, 1'b0, "R1 during hard reset");
    hard_reset();
    expect_st(3'd0, 1'b1, 1'b0, "R1 after hard reset");
    tick(300);
    expect_st(3'd0, 1'b1, 1'b0, "R1 timer and ladder off after reset");
  endtask

  task automatic t_commands();
    hard_reset();
    cmd(3'd1, 8'h00);
    expect_st(3'd1, 1'b1, 1'b0, "R3 idle command");
    cmd(3'd0, 8'h00);
    expect_st(3'd0, 1'b1, 1'b0, "R7 media from idle1");
    cmd(3'd5, 8'h10);
    tick(4);
    expect_st(3'd2, 1'b1, 1'b0, "R5 ladder at idle2");
    cmd(3'd0, 8'h00);
    expect_st(3'd0, 1'b1, 1'b0, "R7 media from idle2");
    cmd(3'd2, 8'h00);
    expect_st(3'd4, 1'b0, 1'b0, "R3 R2 standby command");
    hard_reset();
    cmd(3'd1, 8'h00);
    cmd(3'd3, 8'h00);
    expect_st(3'd5, 1'b0, 1'b0, "R3 R2 sleep command from idle");
  endtask

  task automatic t_timer();
    hard_reset();
    cmd(3'd4, 8'd3);
    tick(2);
    expect_st(3'd0, 1'b1, 1'b0, "R4 before expiry");
    cmd(3'd0, 8'h00);
    tick(2);
    expect_st(3'd0, 1'b1, 1'b0, "R4 command restarts count");
    tick(1);
    expect_st(3'd4, 1'b0, 1'b0, "R4 expiry to standby");
    hard_reset();
    cmd(3'd4, 8'd0);
    tick(300);
    expect_st(3'd0, 1'b1, 1'b0, "R4 zero disables timer");
  endtask

  task automatic t_reserved();
    hard_reset();
    cmd(3'd4, 8'd4);
    tick(2);
    cmd(3'd7, 8'h55);
    tick(1);
    expect_st(3'd0, 1'b1, 1'b0, "R11 reserved no mode change");
    tick(1);
    expect_st(3'd4, 1'b0, 1'b0, "R11 reserved does not restart count");
  endtask

  task automatic t_ladder();
    hard_reset();
    cmd(3'd5, 8'h10);
    tick(2);
    expect_st(3'd1, 1'b1, 1'b0, "R5 step to idle1");
    tick(2);
    expect_st(3'd2, 1'b1, 1'b0, "R5 step to idle2");
    tick(2);
    expect_st(3'd3, 1'b1, 1'b0, "R5 step to idle3");
    tick(1);
    expect_st(3'd3, 1'b1, 1'b0, "R5 mid dwell");
    tick(1);
    expect_st(3'd4, 1'b0, 1'b0, "R5 step to standby");
    hard_reset();
    cmd(3'd5, 8'hFF);
    tick(20);
    expect_st(3'd0, 1'b1, 1'b0, "R5 level FFh ignored");
    cmd(3'd5, 8'h00);
    tick(20);
    expect_st(3'd0, 1'b1, 1'b0, "R5 level 00h ignored");
    cmd(3'd5, 8'h7F);
    tick(3);
    expect_st(3'd0, 1'b1, 1'b0, "R5 band1 before dwell 4");
    tick(1);
    expect_st(3'd1, 1'b1, 1'b0, "R5 band1 dwell 4");
    cmd(3'd5, 8'hC0);
    tick(15);
    expect_st(3'd1, 1'b1, 1'b0, "R5 band3 before dwell 16");
    tick(1);
    expect_st(3'd2, 1'b1, 1'b0, "R5 band3 dwell 16");
    cmd(3'd6, 8'h00);
    tick(40);
    expect_st(3'd2, 1'b1, 1'b0, "R5 ladder off");
  endtask

  task automatic t_race();
    hard_reset();
    cmd(3'd4, 8'd5);
    cmd(3'd5, 8'h10);
    tick(4);
    expect_st(3'd2, 1'b1, 1'b0, "R6 ladder partway");
    tick(1);
    expect_st(3'd4, 1'b0, 1'b0, "R6 timer first");
    hard_reset();
    cmd(3'd4, 8'd10);
    cmd(3'd5, 8'h10);
    tick(7);
    expect_st(3'd3, 1'b1, 1'b0, "R6 ladder at idle3");
    tick(1);
    expect_st(3'd4, 1'b0, 1'b0, "R6 ladder first");
  endtask

  task automatic t_spinup();
    hard_reset();
    cmd(3'd2, 8'h00);
    cmd(3'd0, 8'h00);
    expect_st(3'd4, 1'b0, 1'b1, "R8 media held in standby");
    tick(2);
    expect_st(3'd4, 1'b0, 1'b1, "R8 still spinning up");
    tick(1);
    expect_st(3'd0, 1'b1, 1'b0, "R8 spin-up done to active");
    cmd(3'd2, 8'h00);
    cmd(3'd1, 8'h00);
    tick(2);
    expect_st(3'd4, 1'b0, 1'b0, "R8 idle spin-up without hold");
    tick(1);
    expect_st(3'd1, 1'b1, 1'b0, "R8 idle spin-up done to idle1");
  endtask

  task automatic t_sleep();
    hard_reset();
    cmd(3'd4, 8'd3);
    cmd(3'd3, 8'h00);
    for (int c = 0; c < 8; c++) begin
      cmd(c[2:0], 8'h01);
      expect_st(3'd5, 1'b0, 1'b0, "R9 command ignored in sleep");
    end
    tick(10);
    expect_st(3'd5, 1'b0, 1'b0, "R9 ticks ignored in sleep");
    soft_reset();
    expect_st(3'd4, 1'b0, 1'b0, "R10 soft reset from sleep spins up");
    tick(2);
    expect_st(3'd4, 1'b0, 1'b0, "R10 spin-up in progress");
    tick(1);
    expect_st(3'd0, 1'b1, 1'b0, "R10 soft reset reaches active");
    tick(2);
    expect_st(3'd0, 1'b1, 1'b0, "R9 timer setting not changed in sleep");
    tick(1);
    expect_st(3'd4, 1'b0, 1'b0, "R10 timer kept across soft reset");
    cmd(3'd3, 8'h00);
    hard_reset();
    expect_st(3'd0, 1'b1, 1'b0, "R9 hard reset leaves sleep");
  endtask

  task automatic t_soft_awake();
    hard_reset();
    cmd(3'd5, 8'h10);
    tick(2);
    soft_reset();
    expect_st(3'd0, 1'b1, 1'b0, "R10 soft reset from idle");
    tick(1);
    expect_st(3'd0, 1'b1, 1'b0, "R10 dwell restarted");
    tick(1);
    expect_st(3'd1, 1'b1, 1'b0, "R10 ladder kept across soft reset");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_commands();
    t_timer();
    t_reserved();
    t_ladder();
    t_race();
    t_spinup();
    t_sleep();
    t_soft_awake();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule